// File: doc/BRIEF.md
# PWM Output Protection Request Combiner

This block sits beside a bank of PWM timer channels, each with a complementary pair of outputs (A and B) and a dead-time error flag from its dead-time generator. It registers the A, B and error inputs once. For each channel it then looks for three unsafe conditions: both outputs high together, both outputs low together, and a dead-time error. Each condition has its own permission bit. A permitted condition sets a sticky request flag for that channel.

The channels belong to protection groups through a parameter link mask. A group's disable is the OR of its external disable input and the request flags of its linked channels, and it is registered. While a group disable is high, both outputs of every channel linked to that group are held low. A small register port exposes the following per channel: the permission bits, the flags (cleared by writing 1), and a B-output enable. Per group it gives a packed status word. Two group commands act on all linked channels at once. One turns off the B output of every linked channel that has flagged an illegal pin level. The other turns the B output back on for every linked channel.

Top module: `pwm_protect_combiner`

## Requirements
- R1: After reset all permission bits and flags read 0, every B-output enable reads 1 and every group disable is 0.
- R2: Pins are registered once: when not forced, out_a and out_b equal pwm_a and pwm_b from one clock earlier, and all detection uses these registered values.
- R3: With the both-high permission (channel register 0, bit 29) set, registered A and B both high sets the both-high flag (channel register 1, bit 29) at the next edge.
- R4: With the both-low permission (register 0, bit 30) set, registered A and B both low sets the both-low flag (register 1, bit 30) at the next edge.
- R5: With the dead-time permission (register 0, bit 28) set, a registered dead-time error sets the dead-time flag (register 1, bit 28) at the next edge.
- R6: A condition whose permission bit is 0 sets no flag and causes no group disable.
- R7: Flags are sticky and are cleared only by writing 1 to their bit in register 1. When a clear and a fresh detection of that bit fall in the same cycle, the flag stays set.
- R8: A group disable rises one edge after its external input, or after any linked channel has a flag set. While it is high, out_a and out_b of every linked channel are 0.
- R9: A channel whose link bit in a group is 0 neither drives that group's disable nor shows in that group's status.
- R10: Reading a group (address 0x80 + group) returns a packed word built channel by channel in ascending order. Each step shifts the running value left by 3 and ORs in the channel's 3-bit flag field, or zeros for unlinked channels, so channel 0 ends in the highest field.
- R11: Channel register 2, bit 0, is the B-output enable, writable directly. While it is 0, out_b of that channel is 0.
- R12: A group write with bit 1 set clears the B enable of every linked channel whose both-high or both-low flag is set. A group write with bit 0 set sets the B enable of every linked channel, and bit 0 wins when both bits are set.

Channel registers sit at address channel*4 + index (index 0 permissions, 1 flags, 2 output control); index 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_i | input | NCH | A output of each PWM channel |
| pwm_b_i | input | NCH | B output of each PWM channel |
| dt_err_i | input | NCH | Dead-time error flag per channel |
| ext_dis_i | input | NGRP | External disable per group |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 32 | Read data, combinational from state |
| out_a_o | output | NCH | Protected A outputs |
| out_b_o | output | NCH | Protected B outputs |
| grp_dis_o | output | NGRP | Registered group disable |

## Verification
The assertions assume that all inputs, including the external disables and dead-time flags, are synchronous to clk. They also assume at most one register write per cycle and no more than ten channels, so that a packed group word fits in 32 bits. The stimulus changes every input on the falling edge and issues writes as single-cycle strobes. It mostly drives B as the complement of A, with occasional illegal pairs, rare dead-time errors and rare external disables. Writes go to both valid and reserved addresses, so that flags keep being set and cleared and B enables keep being parked and restored.

// File: rtl/pwm_prot_pkg.sv
package pwm_prot_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CH_SEL_W = 5;
    localparam int FLD_LSB  = 28;
    localparam int NCOND    = 3;

    // condition index inside the 3-bit field; bit position FLD_LSB + index
    localparam int K_DT = 0;
    localparam int K_HI = 1;
    localparam int K_LO = 2;

    typedef enum logic [1:0] {
        CR_PERM   = 2'd0,
        CR_FLAG   = 2'd1,
        CR_OUTCTL = 2'd2,
        CR_RSVD   = 2'd3
    } chan_reg_e;

    localparam logic [1:0] GCMD_REEN = 2'd0;
    localparam logic [1:0] GCMD_PARK = 2'd1;

    typedef struct packed {
        logic [NCOND-1:0] perm;
        logic [NCOND-1:0] flag;
        logic             obe;
    } chan_state_t;

endpackage

// File: rtl/pwm_pin_sampler.sv
module pwm_pin_sampler #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pwm_a,
    input  logic [NCH-1:0] pwm_b,
    input  logic [NCH-1:0] dt_err,
    output logic [NCH-1:0] a_q,
    output logic [NCH-1:0] b_q,
    output logic [NCH-1:0] dt_q
);

    typedef struct packed {
        logic [NCH-1:0] a;
        logic [NCH-1:0] b;
        logic [NCH-1:0] dt;
    } smp_t;

    smp_t smp_d, smp_q;

    // R2: one register stage ahead of all comparisons
    always_comb begin
        smp_d    = smp_q;
        smp_d.a  = pwm_a;
        smp_d.b  = pwm_b;
        smp_d.dt = dt_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign a_q  = smp_q.a;
    assign b_q  = smp_q.b;
    assign dt_q = smp_q.dt;

endmodule

// File: rtl/pwm_chan_monitor.sv
module pwm_chan_monitor
    import pwm_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_q,
    input  logic             b_q,
    input  logic             dt_q,
    input  logic             perm_we,
    input  logic [NCOND-1:0] perm_wdata,
    input  logic             clr_we,
    input  logic [NCOND-1:0] clr_mask,
    input  logic             obe_we,
    input  logic             obe_wdata,
    input  logic             park,
    input  logic             reenable,
    output logic [NCOND-1:0] perm,
    output logic [NCOND-1:0] flag,
    output logic             obe
);

    chan_state_t st_d, st_q;
    logic [NCOND-1:0] cond;
    logic [NCOND-1:0] req;
    logic [NCOND-1:0] clr_eff;
    logic             pin_fault;

    always_comb begin
        cond       = '0;
        cond[K_DT] = dt_q;            // R5
        cond[K_HI] = a_q & b_q;       // R3
        cond[K_LO] = ~a_q & ~b_q;     // R4
        req        = cond & st_q.perm; // R6
        clr_eff    = clr_we ? clr_mask : '0;
        pin_fault  = st_q.flag[K_HI] | st_q.flag[K_LO];

        st_d = st_q;
        if (perm_we) st_d.perm = perm_wdata;
        // R7: detection wins over a simultaneous clear
        st_d.flag = (st_q.flag & ~clr_eff) | req;
        // R12: re-enable has priority over park, park over a direct write
        if (reenable)                st_d.obe = 1'b1;
        else if (park && pin_fault)  st_d.obe = 1'b0;
        else if (obe_we)             st_d.obe = obe_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.obe  <= 1'b1;   // R1
        end else begin
            st_q      <= st_d;
        end
    end

    assign perm = st_q.perm;
    assign flag = st_q.flag;
    assign obe  = st_q.obe;

endmodule

// File: rtl/pwm_group_combiner.sv
module pwm_group_combiner
    import pwm_prot_pkg::*;
#(
    parameter int             NCH  = 4,
    parameter logic [NCH-1:0] LINK = '1,
    localparam int            PACK_W = NCOND * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_dis,
    input  logic [PACK_W-1:0] flag_all,
    output logic              grp_dis,
    output logic [PACK_W-1:0] stat_packed
);

    typedef struct packed {
        logic dis;
    } grp_state_t;

    grp_state_t gs_d, gs_q;
    logic       any_req;

    // R8, R9: OR of linked channel flags and the external input
    always_comb begin
        any_req = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (LINK[c]) any_req = any_req | (|flag_all[c*NCOND +: NCOND]);
        end
        gs_d     = gs_q;
        gs_d.dis = ext_dis | any_req;
    end

    // R10: shift-and-OR walk, channel 0 first
    always_comb begin
        stat_packed = '0;
        for (int c = 0; c < NCH; c++) begin
            stat_packed = stat_packed << NCOND;
            if (LINK[c]) stat_packed[NCOND-1:0] = flag_all[c*NCOND +: NCOND];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gs_q <= '0;
        else        gs_q <= gs_d;
    end

    assign grp_dis = gs_q.dis;

endmodule

// File: rtl/pwm_protect_combiner.sv
module pwm_protect_combiner
    import pwm_prot_pkg::*;
#(
    parameter int                  NCH      = 4,
    parameter int                  NGRP     = 2,
    parameter logic [NGRP*NCH-1:0] GRP_LINK = 8'b0100_0011,
    localparam int                 PACK_W   = NCOND * NCH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      pwm_a_i,
    input  logic [NCH-1:0]      pwm_b_i,
    input  logic [NCH-1:0]      dt_err_i,
    input  logic [NGRP-1:0]     ext_dis_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic [NCH-1:0]      out_a_o,
    output logic [NCH-1:0]      out_b_o,
    output logic [NGRP-1:0]     grp_dis_o
);

    localparam int GSEL_W = ADDR_W - 1;

    logic [NCH-1:0]         a_q, b_q, dt_q;
    logic [PACK_W-1:0]      perm_all, flag_all;
    logic [NCH-1:0]         obe_all;
    logic [NCH-1:0]         park_ch, reen_ch, forced;
    logic [NGRP*PACK_W-1:0] grp_stat;
    logic [NGRP-1:0]        grp_dis_q;

    logic                   wr_is_grp;
    logic [CH_SEL_W-1:0]    wr_ch;
    chan_reg_e              wr_reg;
    logic [GSEL_W-1:0]      wr_grp;
    logic                   unused_wdata;

    assign wr_is_grp    = wr_addr_i[ADDR_W-1];
    assign wr_ch        = wr_addr_i[2 +: CH_SEL_W];
    assign wr_reg       = chan_reg_e'(wr_addr_i[1:0]);
    assign wr_grp       = wr_addr_i[GSEL_W-1:0];
    assign unused_wdata = ^{wr_data_i[31], wr_data_i[27:2]};

    pwm_pin_sampler #(.NCH(NCH)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_a  (pwm_a_i),
        .pwm_b  (pwm_b_i),
        .dt_err (dt_err_i),
        .a_q    (a_q),
        .b_q    (b_q),
        .dt_q   (dt_q)
    );

    // R12: group commands fan out to linked channels
    always_comb begin
        park_ch = '0;
        reen_ch = '0;
        forced  = '0;
        for (int g = 0; g < NGRP; g++) begin
            for (int c = 0; c < NCH; c++) begin
                if (GRP_LINK[g*NCH + c]) begin
                    if (wr_en_i && wr_is_grp && (wr_grp == GSEL_W'(g))) begin
                        park_ch[c] = park_ch[c] | wr_data_i[GCMD_PARK];
                        reen_ch[c] = reen_ch[c] | wr_data_i[GCMD_REEN];
                    end
                    forced[c] = forced[c] | grp_dis_q[g];   // R8
                end
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en_i && !wr_is_grp && (wr_ch == CH_SEL_W'(c));

        pwm_chan_monitor u_mon (
            .clk        (clk),
            .rst_n      (rst_n),
            .a_q        (a_q[c]),
            .b_q        (b_q[c]),
            .dt_q       (dt_q[c]),
            .perm_we    (sel && (wr_reg == CR_PERM)),
            .perm_wdata (wr_data_i[FLD_LSB +: NCOND]),
            .clr_we     (sel && (wr_reg == CR_FLAG)),
            .clr_mask   (wr_data_i[FLD_LSB +: NCOND]),
            .obe_we     (sel && (wr_reg == CR_OUTCTL)),
            .obe_wdata  (wr_data_i[0]),
            .park       (park_ch[c]),
            .reenable   (reen_ch[c]),
            .perm       (perm_all[c*NCOND +: NCOND]),
            .flag       (flag_all[c*NCOND +: NCOND]),
            .obe        (obe_all[c])
        );
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pwm_group_combiner #(
            .NCH  (NCH),
            .LINK (GRP_LINK[g*NCH +: NCH])
        ) u_comb (
            .clk         (clk),
            .rst_n       (rst_n),
            .ext_dis     (ext_dis_i[g]),
            .flag_all    (flag_all),
            .grp_dis     (grp_dis_q[g]),
            .stat_packed (grp_stat[g*PACK_W +: PACK_W])
        );
    end

    // R8, R11: forcing and B enable on the registered pins
    assign out_a_o   = a_q & ~forced;
    assign out_b_o   = b_q & obe_all & ~forced;
    assign grp_dis_o = grp_dis_q;

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i[ADDR_W-1]) begin
            for (int g = 0; g < NGRP; g++) begin
                if (rd_addr_i[GSEL_W-1:0] == GSEL_W'(g))
                    rd_data_o = DATA_W'(grp_stat[g*PACK_W +: PACK_W]);
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_addr_i[2 +: CH_SEL_W] == CH_SEL_W'(c)) begin
                    case (chan_reg_e'(rd_addr_i[1:0]))
                        CR_PERM:   rd_data_o[FLD_LSB +: NCOND] = perm_all[c*NCOND +: NCOND];
                        CR_FLAG:   rd_data_o[FLD_LSB +: NCOND] = flag_all[c*NCOND +: NCOND];
                        CR_OUTCTL: rd_data_o[0] = obe_all[c];
                        default:   rd_data_o = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pwm_prot_checker.sv
module pwm_prot_checker #(
    parameter int                  NCH  = 4,
    parameter int                  NGRP = 2,
    parameter logic [NGRP*NCH-1:0] LINK = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      a_q,
    input logic [NCH-1:0]      b_q,
    input logic [NCH-1:0]      dt_q,
    input logic [3*NCH-1:0]    perm_all,
    input logic [3*NCH-1:0]    flag_all,
    input logic [NCH-1:0]      obe_all,
    input logic [NCH-1:0]      out_a,
    input logic [NCH-1:0]      out_b,
    input logic [NGRP-1:0]     grp_dis,
    input logic [NGRP-1:0]     ext_dis,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic [31:0]         wr_data
);

    logic unused_wd;
    assign unused_wd = ^{wr_data[31], wr_data[27:0]};

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic clr_hit;
        logic frc;
        assign clr_hit = wr_en && (wr_addr == {1'b0, 5'(c), 2'd1});

        always_comb begin
            frc = 1'b0;
            for (int g = 0; g < NGRP; g++)
                if (LINK[g*NCH + c] && grp_dis[g]) frc = 1'b1;
        end

        assert_dt_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dt_q[c] && perm_all[3*c]) |=> flag_all[3*c]);
        assert_hi_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (a_q[c] && b_q[c] && perm_all[3*c+1]) |=> flag_all[3*c+1]);
        assert_lo_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_q[c] && !b_q[c] && perm_all[3*c+2]) |=> flag_all[3*c+2]);

        for (genvar k = 0; k < 3; k++) begin : g_k
            assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_all[3*c+k] && !(clr_hit && wr_data[28+k])) |=> flag_all[3*c+k]);
        end

        assert_forced_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            frc |-> (!out_a[c] && !out_b[c]));
        assert_b_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !obe_all[c] |-> !out_b[c]);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_g
        assert_ext_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ext_dis[g] |=> grp_dis[g]);
    end

endmodule

bind pwm_protect_combiner pwm_prot_checker #(
    .NCH  (NCH),
    .NGRP (NGRP),
    .LINK (GRP_LINK)
) u_prot_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_q      (a_q),
    .b_q      (b_q),
    .dt_q     (dt_q),
    .perm_all (perm_all),
    .flag_all (flag_all),
    .obe_all  (obe_all),
    .out_a    (out_a_o),
    .out_b    (out_b_o),
    .grp_dis  (grp_dis_o),
    .ext_dis  (ext_dis_i),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i)
);

// File: tb/pwm_protect_combiner_bench.sv
`timescale 1ns/1ps
module pwm_protect_combiner_bench;

    localparam int             NCH  = 4;
    localparam int             NGRP = 2;
    localparam logic [7:0]     LINK = 8'b0100_0011;
    localparam time            TCK  = 20ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  pwm_a = '1, pwm_b = '0, dt_err = '0;
    logic [NGRP-1:0] ext_dis = '0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_addr = '0, rd_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [NCH-1:0]  out_a, out_b;
    logic [NGRP-1:0] grp_dis;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(TCK/2) clk = ~clk;

    pwm_protect_combiner #(.NCH(NCH), .NGRP(NGRP), .GRP_LINK(LINK)) u_pwm_protect_combiner (
        .clk(clk), .rst_n(rst_n), .pwm_a_i(pwm_a), .pwm_b_i(pwm_b), .dt_err_i(dt_err),
        .ext_dis_i(ext_dis), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .out_a_o(out_a), .out_b_o(out_b),
        .grp_dis_o(grp_dis)
    );

    // ---------------- reference model from the requirements ----------------
    logic [NCH-1:0]  m_a, m_b, m_dt, m_obe;
    logic [2:0]      m_perm [NCH];
    logic [2:0]      m_flag [NCH];
    logic [NGRP-1:0] m_gd;

    function automatic bit linked(int g, int c);
        return LINK[g*NCH + c];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_dt <= '0; m_obe <= '1; m_gd <= '0;
            for (int c = 0; c < NCH; c++) begin m_perm[c] <= '0; m_flag[c] <= '0; end
        end else begin
            for (int g = 0; g < NGRP; g++) begin
                logic any;
                any = ext_dis[g];
                for (int c = 0; c < NCH; c++) if (linked(g, c) && (m_flag[c] != 0)) any = 1'b1;
                m_gd[g] <= any;
            end
            for (int c = 0; c < NCH; c++) begin
                logic [2:0] req, clr;
                logic park, reen, chw;
                req  = {~m_a[c] & ~m_b[c], m_a[c] & m_b[c], m_dt[c]} & m_perm[c];
                chw  = wr_en && !wr_addr[7] && (wr_addr[6:2] == 5'(c));
                clr  = (chw && wr_addr[1:0] == 2'd1) ? wr_data[30:28] : 3'b000;
                park = 1'b0; reen = 1'b0;
                for (int g = 0; g < NGRP; g++)
                    if (wr_en && wr_addr[7] && wr_addr[6:0] == 7'(g) && linked(g, c)) begin
                        park |= wr_data[1]; reen |= wr_data[0];
                    end
                m_flag[c] <= (m_flag[c] & ~clr) | req;
                if (chw && wr_addr[1:0] == 2'd0) m_perm[c] <= wr_data[30:28];
                if (reen) m_obe[c] <= 1'b1;
                else if (park && (m_flag[c][1] | m_flag[c][2])) m_obe[c] <= 1'b0;
                else if (chw && wr_addr[1:0] == 2'd2) m_obe[c] <= wr_data[0];
            end
            m_a <= pwm_a; m_b <= pwm_b; m_dt <= dt_err;
        end
    end

    function automatic logic [NCH-1:0] m_forced();
        logic [NCH-1:0] f = '0;
        for (int g = 0; g < NGRP; g++)
            for (int c = 0; c < NCH; c++) if (linked(g, c) && m_gd[g]) f[c] = 1'b1;
        return f;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] ad);
        logic [31:0] r = '0;
        if (ad[7]) begin
            if (int'(ad[6:0]) < NGRP)
                for (int c = 0; c < NCH; c++) begin
                    r = r << 3;
                    if (linked(int'(ad[6:0]), c)) r[2:0] = m_flag[c];
                end
        end else if (int'(ad[6:2]) < NCH) begin
            case (ad[1:0])
                2'd0: r[30:28] = m_perm[ad[6:2]];
                2'd1: r[30:28] = m_flag[ad[6:2]];
                2'd2: r[0]     = m_obe[ad[6:2]];
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 out_a", 32'(out_a), 32'(m_a & ~m_forced()));
        check("R11 out_b", 32'(out_b), 32'(m_b & m_obe & ~m_forced()));
        check("R8 grp_dis", 32'(grp_dis), 32'(m_gd));
        check("R10 rd_data", rd_data, m_read(rd_addr));
    endtask

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); compare_all(); end
    endtask

    task automatic wr(logic [7:0] ad, logic [31:0] d);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(string tag, logic [7:0] ad, logic [31:0] exp);
        rd_addr = ad; #1;
        check(tag, rd_data, exp);
    endtask

    function automatic logic [7:0] ch_ad(int c, int r);
        return 8'((c << 2) | r);
    endfunction

    initial begin
        #(TCK * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        tick(2);
        // R1: reset state
        expect_rd("R1 perm", ch_ad(0, 0), 32'h0);
        expect_rd("R1 flag", ch_ad(1, 1), 32'h0);
        expect_rd("R1 obe",  ch_ad(2, 2), 32'h1);
        check("R1 grp_dis", 32'(grp_dis), 32'h0);
        rst_n = 1'b1;
        tick(2);

        // R3: both-high on ch0
        wr(ch_ad(0, 0), 32'h7000_0000);
        pwm_b[0] = 1'b1; tick(1); pwm_b[0] = 1'b0; tick(3);
        expect_rd("R3 flag hi", ch_ad(0, 1), 32'h2000_0000);
        check("R8 grp0 from ch0", 32'(grp_dis), 32'h1);
        check("R8 forced a", 32'(out_a[0]), 32'h0);

        // R7: clear and detect in the same cycle keeps the flag
        pwm_b[0] = 1'b1; tick(1);
        wr(ch_ad(0, 1), 32'h2000_0000);
        pwm_b[0] = 1'b0; tick(2);
        expect_rd("R7 collide keeps", ch_ad(0, 1), 32'h2000_0000);
        wr(ch_ad(0, 1), 32'h7000_0000); tick(2);
        expect_rd("R7 w1c clears", ch_ad(0, 1), 32'h0);
        check("R8 grp0 released", 32'(grp_dis), 32'h0);

        // R4: both-low on ch0
        pwm_a[0] = 1'b0; tick(1); pwm_a[0] = 1'b1; tick(2);
        expect_rd("R4 flag lo", ch_ad(0, 1), 32'h4000_0000);
        // R5: dead-time on ch0
        dt_err[0] = 1'b1; tick(1); dt_err[0] = 1'b0; tick(2);
        expect_rd("R5 flag dt", ch_ad(0, 1), 32'h5000_0000);
        wr(ch_ad(0, 1), 32'h7000_0000); tick(3);

        // R6: ch1 without permission
        pwm_b[1] = 1'b1; tick(1); pwm_b[1] = 1'b0; tick(3);
        expect_rd("R6 no flag", ch_ad(1, 1), 32'h0);
        check("R6 no disable", 32'(grp_dis), 32'h0);

        // R9: ch3 is unlinked
        wr(ch_ad(3, 0), 32'h2000_0000);
        pwm_b[3] = 1'b1; tick(1); pwm_b[3] = 1'b0; tick(3);
        expect_rd("R9 ch3 flag", ch_ad(3, 1), 32'h2000_0000);
        check("R9 no disable", 32'(grp_dis), 32'h0);
        expect_rd("R9 grp0 word", 8'h80, 32'h0);
        expect_rd("R9 grp1 word", 8'h81, 32'h0);

        // R10: ch2 both-high in group 1 -> field at bits 5:3
        wr(ch_ad(2, 0), 32'h2000_0000);
        pwm_b[2] = 1'b1; tick(1); pwm_b[2] = 1'b0; tick(2);
        expect_rd("R10 packed", 8'h81, 32'h0000_0010);

        // R12: park then re-enable (bit0 wins)
        wr(8'h81, 32'h2); tick(1);
        expect_rd("R12 parked", ch_ad(2, 2), 32'h0);
        wr(8'h81, 32'h3); tick(1);
        expect_rd("R12 reenabled", ch_ad(2, 2), 32'h1);

        // R11: direct B enable clear on ch1
        wr(ch_ad(1, 2), 32'h0);
        pwm_a[1] = 1'b0; pwm_b[1] = 1'b1; tick(2);
        check("R11 b gated", 32'(out_b[1]), 32'h0);
        check("R2 a follows", 32'(out_a[1]), 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                pwm_a[c]  = 1'($urandom);
                pwm_b[c]  = ($urandom % 10 == 0) ? 1'($urandom) : ~pwm_a[c];
                dt_err[c] = ($urandom % 40 == 0);
            end
            for (int g = 0; g < NGRP; g++) ext_dis[g] = ($urandom % 60 == 0);
            rd_addr = ($urandom % 4 == 0) ? 8'(8'h80 | ($urandom % 3))
                                          : ch_ad(int'($urandom % 5), int'($urandom % 4));
            if ($urandom % 5 == 0) begin
                wr_en   = 1'b1;
                wr_addr = ($urandom % 4 == 0) ? 8'(8'h80 | ($urandom % NGRP))
                                              : ch_ad(int'($urandom % NCH), int'($urandom % 4));
                wr_data = $urandom;
            end else begin
                wr_en = 1'b0;
            end
            tick(1);
        end
        wr_en = 1'b0;
        tick(2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule